// File: doc/BRIEF.md
# Mod-3 Channel Hash Generator

This block spreads memory traffic evenly over three channels. Instead of taking a power-of-two slice of the address, it builds a residue modulo 3 and carries it as a 3-bit one-hot vector. The residue index 0 is written `100`, index 1 is `010` and index 2 is `001`.

The starting residue is a one-hot code made from a 2-bit address field. That code then passes through a chain of conditional right rotations. Two of them are controlled by further address fields, and the last is controlled by the two most significant port-address bits. Each right rotation by one step advances the residue index by one, modulo 3.

The block returns two results. The first is the partial residue, which depends on the real address alone. The second is the final channel hash. Both are registered and appear together with a valid strobe one clock after the inputs are accepted.

Top module: `mod3_channel_hash`

## Requirements
- R1: The seed code of a 2-bit field v is `100` for v=0 or v=3, `010` for v=1 and `001` for v=2. The seed field is real-address bits [16:15], counted from bit 0 as the least significant. With bits [20:17] and the port MSBs at zero, `res_partial` equals the seed code.
- R2: One right rotation step moves bit 0 of the vector into bit 2 and shifts bits [2:1] down into bits [1:0]. So `100` becomes `010`, `010` becomes `001`, and `001` becomes `100`.
- R3: The seed is rotated right by the value of address bits [18:17]. That result is rotated right by the value of bits [20:19] to give `res_partial`.
- R4: `chan_hash` equals `res_partial` rotated right by the value of `port_msb`.
- R5: A rotation count of 3 gives the same vector as a count of 0. This holds for every address field and for `port_msb`.
- R6: `res_partial` and `chan_hash` are always exactly one-hot. Read as residue indices, they equal (f0+f1+f2) mod 3 and (f0+f1+f2+m) mod 3. Here f0, f1 and f2 are the values of the three address fields and m is the value of `port_msb`.
- R7: Inputs are captured on a rising clock edge where `in_valid` is high. The results and `out_valid` high appear after that edge.
- R8: After an edge where `in_valid` is low, `out_valid` is low and both results keep their previous values.
- R9: A synchronous active-low reset drives `out_valid` low and sets both results to `100`.
- R10: Address bits outside [20:15] have no effect on either result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Capture strobe for the inputs |
| real_addr | input | 64 | Real address to be hashed |
| port_msb | input | 2 | Two most significant port-address bits |
| out_valid | output | 1 | High for one cycle after each capture |
| res_partial | output | 3 | One-hot residue from the address alone |
| chan_hash | output | 3 | One-hot channel select |

## Verification
The assertions assume that `in_valid`, `real_addr` and `port_msb` hold known values at every rising edge once reset is released. They also assume that reset lasts at least one edge before any check runs.

The stimulus changes inputs only on falling edges and never drives X. Reset is held low for several edges at the start and again once in the middle of the run. The random stimulus covers all four values of every 2-bit field, including the value 3 that wraps to a rotation of 0.

// File: rtl/mod3_hash_pkg.sv
package mod3_hash_pkg;

  localparam int RES_W = 3;
  typedef logic [RES_W-1:0] res_t;

  localparam res_t RES_ZERO = 3'b100;

  // one-hot code for a 2-bit value: 100 shifted right by (v mod 3)
  function automatic res_t seed_code(input logic [1:0] v);
    res_t r;
    r = RES_ZERO >> (v % 2'd3);
    return r;
  endfunction

  // single right-rotation step of a 3-bit one-hot vector
  function automatic res_t rot_step(input res_t v);
    return {v[0], v[2:1]};
  endfunction

  // n rotation steps
  function automatic res_t rot_by(input res_t v, input int n);
    res_t r;
    r = v;
    for (int i = 0; i < n; i++) begin
      r = rot_step(r);
    end
    return r;
  endfunction

endpackage

// File: rtl/m3h_seed.sv
module m3h_seed
  import mod3_hash_pkg::*;
(
  input  logic [1:0] field,
  output res_t       code
);
  assign code = seed_code(field);
endmodule

// File: rtl/m3h_rotator.sv
module m3h_rotator
  import mod3_hash_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  res_t             vec_in,
  input  logic [CNT_W-1:0] count,
  output res_t             vec_out
);
  localparam int N_CAND = 1 << CNT_W;

  res_t cand [N_CAND];

  for (genvar k = 0; k < N_CAND; k++) begin : g_cand
    assign cand[k] = rot_by(vec_in, k);
  end

  assign vec_out = cand[count];
endmodule

// File: rtl/mod3_channel_hash.sv
module mod3_channel_hash
  import mod3_hash_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int SEED_LSB = 15,
  parameter int ROT1_LSB = 17,
  parameter int ROT2_LSB = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] real_addr,
  input  logic [1:0]        port_msb,
  output logic              out_valid,
  output logic [2:0]        res_partial,
  output logic [2:0]        chan_hash
);
  localparam int FLD_W = 2;

  // named internal stages, visible to the checker
  logic [FLD_W-1:0] fld_seed, fld_rot1, fld_rot2;
  res_t r0_code, r1_code, r2_code, r3_code;
  logic addr_unused;

  assign fld_seed = real_addr[SEED_LSB +: FLD_W];
  assign fld_rot1 = real_addr[ROT1_LSB +: FLD_W];
  assign fld_rot2 = real_addr[ROT2_LSB +: FLD_W];
  assign addr_unused = ^real_addr;

  m3h_seed u_seed (
    .field (fld_seed),
    .code  (r0_code)
  );

  m3h_rotator #(.CNT_W(FLD_W)) u_rot1 (
    .vec_in  (r0_code),
    .count   (fld_rot1),
    .vec_out (r1_code)
  );

  m3h_rotator #(.CNT_W(FLD_W)) u_rot2 (
    .vec_in  (r1_code),
    .count   (fld_rot2),
    .vec_out (r2_code)
  );

  m3h_rotator #(.CNT_W(FLD_W)) u_rot3 (
    .vec_in  (r2_code),
    .count   (port_msb),
    .vec_out (r3_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      res_partial <= RES_ZERO;
      chan_hash   <= RES_ZERO;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_partial <= r2_code;
        chan_hash   <= r3_code;
      end
    end
  end
endmodule

// File: rtl/m3h_checker.sv
module m3h_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] port_msb,
  input logic       out_valid,
  input logic [2:0] res_partial,
  input logic [2:0] chan_hash,
  input logic [2:0] r2_code,
  input logic [2:0] r3_code
);
  // R6: outputs one-hot
  p_onehot_hash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chan_hash) == 1);
  p_onehot_part_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(res_partial) == 1);

  // R7: capture followed by valid and captured value
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid && res_partial == $past(r2_code) && chan_hash == $past(r3_code));

  // R8: idle cycle holds results
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(res_partial) && $stable(chan_hash));

  // R4 / R5: port MSBs of 0 or 3 leave the partial residue unchanged
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (port_msb == 2'd0 || port_msb == 2'd3) |=> chan_hash == res_partial);

  // R4: port MSBs of 1 give one right step
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && port_msb == 2'd1 |=> chan_hash == {res_partial[0], res_partial[2:1]});
endmodule

bind mod3_channel_hash m3h_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .port_msb    (port_msb),
  .out_valid   (out_valid),
  .res_partial (res_partial),
  .chan_hash   (chan_hash),
  .r2_code     (r2_code),
  .r3_code     (r3_code)
);

// File: tb/sim_mod3_channel_hash.sv
`timescale 1ns/1ps
module sim_mod3_channel_hash;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] real_addr = '0;
  logic [1:0]  port_msb = '0;
  logic        out_valid;
  logic [2:0]  res_partial, chan_hash;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  logic       e_valid = 1'b0;
  logic [2:0] e_part = 3'b100;
  logic [2:0] e_hash = 3'b100;

  always #5 clk = ~clk;

  mod3_channel_hash u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .real_addr(real_addr),
    .port_msb(port_msb), .out_valid(out_valid), .res_partial(res_partial),
    .chan_hash(chan_hash)
  );

  function automatic logic [2:0] idx_to_vec(input int idx);
    case (idx % 3)
      0: return 3'b100;
      1: return 3'b010;
      default: return 3'b001;
    endcase
  endfunction

  task automatic cmp(input string tag);
    n_cmp++;
    if (out_valid !== e_valid) begin
      n_bad++;
      $display("FAIL %s out_valid act=%b exp=%b", tag, out_valid, e_valid);
    end
    n_cmp++;
    if (res_partial !== e_part) begin
      n_bad++;
      $display("FAIL %s res_partial act=%b exp=%b", tag, res_partial, e_part);
    end
    n_cmp++;
    if (chan_hash !== e_hash) begin
      n_bad++;
      $display("FAIL %s chan_hash act=%b exp=%b", tag, chan_hash, e_hash);
    end
  endtask

  // drive one cycle at a falling edge, compare at the next falling edge
  task automatic step(input logic rst_v, input logic v, input logic [63:0] a,
                      input logic [1:0] m, input string tag);
    int f0, f1, f2;
    rst_n = rst_v; in_valid = v; real_addr = a; port_msb = m;
    f0 = int'(a[16:15]); f1 = int'(a[18:17]); f2 = int'(a[20:19]);
    if (!rst_v) begin
      e_valid = 1'b0; e_part = 3'b100; e_hash = 3'b100;
    end else begin
      e_valid = v;
      if (v) begin
        e_part = idx_to_vec(f0 + f1 + f2);
        e_hash = idx_to_vec(f0 + f1 + f2 + int'(m));
      end
    end
    @(negedge clk);
    cmp(tag);
  endtask

  function automatic logic [63:0] mk(input int s, input int a1, input int a2);
    logic [63:0] r;
    r = '0;
    r[16:15] = 2'(s); r[18:17] = 2'(a1); r[20:19] = 2'(a2);
    return r;
  endfunction

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, '1, 2'd1, "R9 reset");
    // R1 seed codes
    for (int s = 0; s < 4; s++) step(1'b1, 1'b1, mk(s, 0, 0), 2'd0, "R1 seed");
    // R2 single step from each one-hot value
    for (int s = 0; s < 3; s++) step(1'b1, 1'b1, mk(s, 1, 0), 2'd0, "R2 step");
    // R3 chained address rotations
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 4; c++) step(1'b1, 1'b1, mk(1, b, c), 2'd0, "R3 chain");
    // R4 port MSB rotation
    for (int m = 0; m < 4; m++) step(1'b1, 1'b1, mk(2, 1, 2), 2'(m), "R4 msb");
    // R5 count 3 equals count 0
    step(1'b1, 1'b1, mk(1, 3, 3), 2'd3, "R5 wrap");
    step(1'b1, 1'b1, mk(1, 0, 0), 2'd0, "R5 wrap");
    // R8 hold with changing inputs
    step(1'b1, 1'b0, mk(2, 2, 2), 2'd1, "R8 hold");
    step(1'b1, 1'b0, '1, 2'd2, "R8 hold");
    // R10 unrelated bits ignored
    step(1'b1, 1'b1, 64'hFFFF_FFFF_FFE0_7FFF, 2'd0, "R10 ignore");
    step(1'b1, 1'b1, 64'hA5A5_5A5A_C3E0_1234 | mk(2, 1, 0), 2'd2, "R10 ignore");
    // R9 mid-run reset
    step(1'b0, 1'b1, mk(1, 1, 1), 2'd1, "R9 reset");
    step(1'b1, 1'b0, mk(1, 1, 1), 2'd1, "R9 after");
    // R6 R7 random stream
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] ra;
      ra = {$urandom, $urandom};
      step(1'b1, ($urandom % 4) != 0, ra, 2'($urandom), "R6 R7 random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=hung exp=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule